// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words while generating the serial clock itself. A baud divider sets the clock rate, and the block samples a data line on each falling clock edge. It assembles 8-bit words, or 9-bit words when the wide mode is chosen, with the least significant bit arriving first. Finished words go into a two-entry receive buffer. Software reads them from the head of that buffer, together with the ninth bit when it is present.

Two controls start reception. A single-shot request sets an internal flag. The block then receives one word, stops the clock and clears the flag. A continuous enable is a level from software: while it is high, words are received back to back. When both are active, the continuous enable decides what happens.

A ready output and an interrupt request, qualified by an interrupt enable, announce buffered data. An overrun bit latches when a word completes while the buffer is full. Dropping the continuous enable clears that bit.

Top module: `sync_master_rx`

## Requirements
- R1: While receiving, `sclk` has a period of 4 × (`baud_div` + 1) system clocks, and each half period lasts 2 × (`baud_div` + 1) clocks. A new word starts with `sclk` low. Whenever the block is not receiving, `sclk` is held low.
- R2: `sdata` is sampled in the system cycle in which `sclk` goes from high to low. The first sample becomes bit 0, the next becomes bit 1, and so on. The finished word appears on `rx_data`.
- R3: A pulse on `single_set` (with `cont_en` low) sets `single_busy`. The block then receives exactly one word. On that word's last falling edge `single_busy` clears, and `sclk` stays low afterwards.
- R4: While `cont_en` is high (and `port_en` is high), words are received back to back without a gap.
- R5: While `cont_en` is high, a completed word does not clear `single_busy`. When `cont_en` falls, any partly received word is dropped. If `single_busy` is still set at that point, one further complete word is then received.
- R6: `rx_ready` is high whenever the buffer holds at least one word. `irq` is high only when `rx_ready` and `irq_en` are both high.
- R7: With `nine_bit` = 1, a word has 9 bits and its bit 8 (the ninth sample) appears on `rx_bit9`. With `nine_bit` = 0, a word has 8 bits and `rx_bit9` reads 0.
- R8: The buffer holds two words in arrival order. A one-cycle pulse on `rd` removes the head word. `rx_ready` drops once every word has been read.
- R9: If a word completes while both entries are full and `rd` is low, `overrun` is set and the word is discarded. While `overrun` is set, no completed word enters the buffer.
- R10: A falling edge of `cont_en` clears `overrun`.
- R11: While `port_en` is low, no clock is generated and no word is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Serial port enabled in synchronous master mode |
| baud_div | input | 8 | Baud divider value |
| nine_bit | input | 1 | 1 selects 9-bit words |
| single_set | input | 1 | Pulse that requests one word |
| cont_en | input | 1 | Continuous receive enable |
| irq_en | input | 1 | Receive interrupt enable |
| rd | input | 1 | Pulse that reads and removes the head word |
| sdata | input | 1 | Serial data line |
| sclk | output | 1 | Generated serial clock |
| rx_data | output | 8 | Low 8 bits of the head word |
| rx_bit9 | output | 1 | Ninth bit of the head word |
| rx_ready | output | 1 | Receive-complete flag (buffer not empty) |
| overrun | output | 1 | Overrun error, latched |
| single_busy | output | 1 | Single-shot request still pending |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit divider and a two-entry buffer. It drives run-time divider values of 0 and 1, which keep serial periods at 4 and 8 system clocks. At these rates, whole sequences fit in a short run: several back-to-back words, the buffer filling up, overrun, and recovery from it. A behavioural model built from queues tracks every output on every clock. Directed checks then confirm the data values, the measured period and the precedence between the two enables.

// File: rtl/sync_master_rx.sv
module sync_master_rx #(
  parameter int DIV_W = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             nine_bit,
  input  logic             single_set,
  input  logic             cont_en,
  input  logic             irq_en,
  input  logic             rd,
  input  logic             sdata,
  output logic             sclk,
  output logic [7:0]       rx_data,
  output logic             rx_bit9,
  output logic             rx_ready,
  output logic             overrun,
  output logic             single_busy,
  output logic             irq
);
  localparam int CW = DIV_W + 2;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt;
  logic [3:0]    bitn;
  logic [8:0]    sh, capt, word;
  logic          cont_q, active, cont_fall, edge_hit, done, pop, push;
  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;

  assign active    = port_en & (cont_en | single_busy);
  assign cont_fall = cont_q & ~cont_en;
  assign edge_hit  = active & ~cont_fall & (cnt == {1'b0, baud_div, 1'b1});
  assign done      = edge_hit & sclk & (bitn == (nine_bit ? 4'd8 : 4'd7));
  assign pop       = rd & (count != 0);
  assign push      = done & ~overrun & ((count != (AW+1)'(DEPTH)) | pop);

  always_comb begin
    capt = sh;
    capt[bitn] = sdata;
    word = nine_bit ? capt : {1'b0, capt[7:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sclk <= 1'b0;
      bitn <= '0;
      sh <= '0;
    end else if (!active || cont_fall) begin
      cnt <= '0;
      sclk <= 1'b0;
      bitn <= '0;
    end else if (edge_hit) begin
      cnt <= '0;
      sclk <= ~sclk;
      if (sclk) begin
        sh <= capt;
        bitn <= done ? 4'd0 : bitn + 4'd1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont_q <= 1'b0;
      single_busy <= 1'b0;
      overrun <= 1'b0;
    end else begin
      cont_q <= cont_en;
      if (done && !cont_en) single_busy <= 1'b0;
      if (single_set) single_busy <= 1'b1;
      if (cont_fall) overrun <= 1'b0;
      else if (done && !overrun && !push) overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wp] <= word;
        wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (push && !pop) count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign rx_data  = mem[rp][7:0];
  assign rx_bit9  = mem[rp][8];
  assign rx_ready = (count != 0);
  assign irq      = rx_ready & irq_en;
endmodule

module sync_master_rx_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             port_en,
  input logic [DIV_W-1:0] baud_div,
  input logic             nine_bit,
  input logic             single_set,
  input logic             cont_en,
  input logic             irq_en,
  input logic             rd,
  input logic             sdata,
  input logic             sclk,
  input logic [7:0]       rx_data,
  input logic             rx_bit9,
  input logic             rx_ready,
  input logic             overrun,
  input logic             single_busy,
  input logic             irq
);
  a_r11_no_clock_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !sclk);
  a_r6_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_ready && irq_en));
  a_r8_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rd) |=> rx_ready);
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && cont_en) |=> overrun);
  a_r10_overrun_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_en && $past(cont_en)) |=> !overrun);
  a_r3_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(single_busy) |-> !sclk);
endmodule

bind sync_master_rx sync_master_rx_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sync_master_rx_test.sv
module sync_master_rx_test;
  logic clk = 0, rst_n = 0, port_en = 0, nine_bit = 0, single_set = 0;
  logic cont_en = 0, irq_en = 0, rd = 0, sdata = 0;
  logic [7:0] baud_div = 8'd1;
  logic sclk, rx_bit9, rx_ready, overrun, single_busy, irq;
  logic [7:0] rx_data;
  logic [8:0] tx_word = '0;
  int tests = 0, fails = 0;

  sync_master_rx uut (.*);

  always #10 clk = ~clk;

  int m_cnt = 0, m_bit = 0;
  bit m_sclk = 0, m_single = 0, m_contq = 0, m_ovr = 0;
  logic [8:0] m_sh = '0;
  logic [8:0] q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_bit = 0; m_sclk = 0; m_single = 0; m_contq = 0; m_ovr = 0;
      m_sh = '0; q.delete();
    end else begin
      bit act, fall, done, popd;
      int last;
      act = port_en && (cont_en || m_single);
      fall = m_contq && !cont_en;
      last = nine_bit ? 8 : 7;
      done = 0;
      popd = rd && q.size() > 0;
      if (!act || fall) begin
        m_cnt = 0; m_sclk = 0; m_bit = 0;
      end else if (m_cnt == 2 * int'(baud_div) + 1) begin
        m_cnt = 0;
        if (m_sclk) begin
          m_sh[m_bit] = sdata;
          if (m_bit == last) begin done = 1; m_bit = 0; end
          else m_bit++;
        end
        m_sclk = !m_sclk;
      end else m_cnt++;
      if (popd) void'(q.pop_front());
      if (done && !m_ovr) begin
        if (q.size() == 2) m_ovr = 1;
        else q.push_back(nine_bit ? m_sh : {1'b0, m_sh[7:0]});
      end
      if (done && !cont_en) m_single = 0;
      if (single_set) m_single = 1;
      if (fall) m_ovr = 0;
      m_contq = cont_en;
    end
  end

  always @(negedge clk) sdata = tx_word[m_bit];

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit rdy;
      rdy = q.size() > 0;
      chk("R1 sclk vs model", sclk, m_sclk);
      chk("R6 rx_ready vs model", rx_ready, rdy);
      chk("R6 irq vs model", irq, rdy && irq_en);
      chk("R9 overrun vs model", overrun, m_ovr);
      chk("R3 single_busy vs model", single_busy, m_single);
      if (rdy) begin
        chk("R2 rx_data vs model", rx_data, q[0][7:0]);
        chk("R7 rx_bit9 vs model", rx_bit9, q[0][8]);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_one();
    while (!rx_ready) @(negedge clk);
    rd = 1; @(negedge clk); rd = 0;
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
    cyc(3);
    chk("R1 reset sclk", sclk, 0);
    chk("R6 reset rx_ready", rx_ready, 0);
    chk("R9 reset overrun", overrun, 0);
    chk("R6 reset irq", irq, 0);
    rst_n = 1; port_en = 1; cyc(2);

    tx_word = 9'h0A5; baud_div = 8'd1;
    single_set = 1; @(negedge clk); single_set = 0;
    chk("R3 single_busy set", single_busy, 1);
    while (single_busy) @(negedge clk);
    chk("R2 single word data", rx_data, 8'hA5);
    chk("R7 eight-bit ninth", rx_bit9, 0);
    chk("R6 ready after word", rx_ready, 1);
    chk("R6 irq masked", irq, 0);
    irq_en = 1; @(negedge clk);
    chk("R6 irq enabled", irq, 1);
    cyc(30);
    chk("R3 clock stopped", sclk, 0);
    rd = 1; @(negedge clk); rd = 0;
    chk("R8 empty after read", rx_ready, 0);

    nine_bit = 1; baud_div = 8'd0; tx_word = 9'h1C3; cont_en = 1;
    begin
      int per;
      while (sclk) @(negedge clk);
      while (!sclk) @(negedge clk);
      per = 0;
      do begin @(negedge clk); per++; end while (!(sclk && per > 1));
      chk("R1 period div0", per, 4);
    end
    while (!overrun) @(negedge clk);
    chk("R9 overrun raised", overrun, 1);
    tx_word = 9'h05A;
    cyc(100);
    chk("R7 ninth bit", rx_bit9, 1);
    chk("R4 first word", rx_data, 8'hC3);
    rd = 1; @(negedge clk); rd = 0;
    chk("R8 second entry kept", rx_ready, 1);
    chk("R9 old word kept", rx_data, 8'hC3);
    rd = 1; @(negedge clk); rd = 0;
    chk("R9 nothing stored while overrun", rx_ready, 0);
    cont_en = 0; cyc(2);
    chk("R10 overrun cleared", overrun, 0);
    chk("R10 clock idle", sclk, 0);

    nine_bit = 0; baud_div = 8'd1; tx_word = 9'h033;
    cont_en = 1; single_set = 1; @(negedge clk); single_set = 0;
    read_one(); read_one();
    chk("R5 single kept under continuous", single_busy, 1);
    cont_en = 0;
    while (single_busy) @(negedge clk);
    chk("R5 final single word", rx_data, 8'h33);
    read_one(); cyc(2);
    chk("R5 one word after drop", rx_ready, 0);

    port_en = 0; cont_en = 1;
    begin
      int seen = 0;
      repeat (60) begin @(negedge clk); seen += sclk; end
      chk("R11 no clock when off", seen, 0);
      chk("R11 no word when off", rx_ready, 0);
    end
    cont_en = 0; cyc(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule